// File: doc/BRIEF.md
# DDR Two-Word Prefetch Serializer

This block sits between a memory core that moves one double-width word per clock and a pin interface that moves a single-width beat on every clock edge. On the read side it accepts one 2n-bit word per clock and sends it as two n-bit beats. The low half goes out while the clock is high and the high half while the clock is low. It also drives a strobe that follows the clock for every beat and turns on a shared pin output enable. On the write side it captures an n-bit beat on each edge of a strobe driven from outside. It rebuilds the 2n-bit words and hands each one to the core with a one-cycle valid pulse.

A burst is started by a one-cycle request sampled on the rising clock edge. The burst length is given by a two-bit code that is latched at the start. A small state machine has three states: IDLE, READ and WRITE. It has five named transitions. START_RD goes from IDLE to READ, and START_WR goes from IDLE to WRITE. RD_CHAIN stays in READ and reloads the count. RD_DONE goes from READ to IDLE, and WR_DONE goes from WRITE to IDLE. Positive-edge and negative-edge register stages are kept apart, so each clock phase has its own single-edge flops.

Top module: `ddr_prefetch_serdes`

## Requirements
- R1: While reset is low and on the first cycle after it, `pin_oe`, `dqs_out`, `rd_take` and `wr_valid` are all 0.
- R2: A `rd_start` sampled in IDLE loads the length code `blen_sel`. The codes are 0 for 2 beats, 1 for 4 beats, and 2 or 3 for 8 beats. From the next cycle on, `rd_take` is high for exactly beats/2 cycles, and `rd_word` is taken on each rising edge inside that window.
- R3: A word taken at rising edge e appears on `dq_out` in two halves. Bits [n-1:0] are shown while the clock is high after e, and bits [2n-1:n] while the clock is low after e.
- R4: In every cycle that follows an edge where a word was taken, `pin_oe` is 1. In that cycle `dqs_out` equals the clock: high in the high phase and low in the low phase.
- R5: In a cycle that follows an edge where no word was taken, `pin_oe` and `dqs_out` are both 0.
- R6: During a write burst, `dq_in` is captured on the rising edge of `dqs_in` as the low half and on the falling edge as the high half. The assembled word appears on `wr_word` with a one-cycle `wr_valid` pulse at the first rising clock edge after the falling strobe edge.
- R7: A write burst delivers exactly beats/2 words, then returns to IDLE. Strobe pulses after that produce no `wr_valid`, and `pin_oe` stays 0 throughout the write.
- R8: Strobe pulses on `dqs_in` seen outside a write burst are discarded. They produce no `wr_valid` and do not appear in the words of a later write burst.
- R9: `rd_start` and `wr_start` are ignored while a burst is in progress, except in the case given in R10.
- R10: A `rd_start` sampled at the edge that takes the last word of a read burst begins a new read burst. The new burst's first word is taken at the very next edge, so `rd_take`, `pin_oe` and the strobe continue without a gap.
- R11: When `rd_start` and `wr_start` are both sampled in IDLE, the read burst starts and the write request is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; its high and low phases each carry one beat |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_start | input | 1 | Request to begin a read burst |
| wr_start | input | 1 | Request to begin a write burst |
| blen_sel | input | 2 | Burst length code: 0 = 2, 1 = 4, 2 or 3 = 8 beats |
| rd_word | input | 2*BEAT_W | Core word to be sent, taken on edges where `rd_take` is high |
| rd_take | output | 1 | High in cycles whose closing edge takes `rd_word` |
| dq_out | output | BEAT_W | Beat driven toward the pins |
| dqs_out | output | 1 | Read strobe driven toward the pins |
| pin_oe | output | 1 | Output enable shared by data and strobe drivers |
| dq_in | input | BEAT_W | Beat received from the pins |
| dqs_in | input | 1 | Strobe received from the pins during writes |
| wr_word | output | 2*BEAT_W | Rebuilt write word |
| wr_valid | output | 1 | One-cycle pulse marking a new `wr_word` |

## Verification
The last-word edge of a read burst and a fresh read request can fall on the same rising edge. The bench provokes this by raising `rd_start` in the final cycle of a burst. It checks that the strobe, the enable and both beat halves continue with no idle cycle between the bursts. A second collision is raised by asserting both start requests together in IDLE. That case is judged by a normal read burst and by the absence of any write word afterwards. Start requests aimed into running read and write bursts are also shown to leave the burst length unchanged.

// File: rtl/ddr_serdes_pkg.sv
package ddr_serdes_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } burst_state_e;

    // Number of internal (double-width) words moved by a burst code.
    function automatic int unsigned words_for(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 1;
            2'd1:    return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/ddr_burst_ctrl.sv
module ddr_burst_ctrl
    import ddr_serdes_pkg::*;
#(
    parameter int MAX_WORDS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_start,
    input  logic         wr_start,
    input  logic [1:0]   blen_sel,
    input  logic         word_evt,
    output burst_state_e state,
    output logic         rd_take,
    output logic         wr_en,
    output logic         wr_arm
);

    localparam int CNT_W = $clog2(MAX_WORDS + 1);

    burst_state_e      state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [CNT_W-1:0]  load_val;

    assign load_val = CNT_W'(words_for(blen_sel));

    // Next-state and count logic
    always_comb begin
        state_d = state;
        cnt_d   = cnt_q;
        unique case (state)
            ST_IDLE: begin
                if (rd_start) begin                 // START_RD
                    state_d = ST_READ;
                    cnt_d   = load_val;
                end else if (wr_start) begin        // START_WR
                    state_d = ST_WRITE;
                    cnt_d   = load_val;
                end
            end
            ST_READ: begin
                if (cnt_q == CNT_W'(1)) begin
                    if (rd_start) begin             // RD_CHAIN
                        cnt_d = load_val;
                    end else begin                  // RD_DONE
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_WRITE: begin
                if (word_evt) begin
                    if (cnt_q == CNT_W'(1)) begin   // WR_DONE
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            state <= state_d;
            cnt_q <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        rd_take = 1'b0;
        wr_en   = 1'b0;
        wr_arm  = 1'b0;
        unique case (state)
            ST_IDLE:  wr_arm  = wr_start && !rd_start;
            ST_READ:  rd_take = 1'b1;
            ST_WRITE: wr_en   = 1'b1;
            default:  ;
        endcase
    end

    // R2: an active burst always has words left to move
    a_r2_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (cnt_q != '0));

    // R9: a write burst waiting for a word ignores start requests
    a_r9_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && !word_evt) |=> (state == ST_WRITE));

endmodule

// File: rtl/ddr_rd_serializer.sv
module ddr_rd_serializer #(
    parameter int BEAT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_take,
    input  logic [2*BEAT_W-1:0] rd_word,
    output logic [BEAT_W-1:0]   dq_out,
    output logic                dqs_out,
    output logic                pin_oe
);

    localparam int WORD_W = 2 * BEAT_W;

    logic [BEAT_W-1:0] lo_pos_q;
    logic [BEAT_W-1:0] hi_pos_q;
    logic [BEAT_W-1:0] hi_neg_q;
    logic              vld_pos_q;

    // Rising-edge stage: split the word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_pos_q  <= '0;
            hi_pos_q  <= '0;
            vld_pos_q <= 1'b0;
        end else begin
            vld_pos_q <= rd_take;
            if (rd_take) begin
                lo_pos_q <= rd_word[BEAT_W-1:0];
                hi_pos_q <= rd_word[WORD_W-1:BEAT_W];
            end
        end
    end

    // Falling-edge stage: hand the upper half to the low phase
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_neg_q <= '0;
        end else begin
            hi_neg_q <= hi_pos_q;
        end
    end

    assign dq_out  = clk ? lo_pos_q : hi_neg_q;
    assign dqs_out = clk & vld_pos_q;
    assign pin_oe  = vld_pos_q;

endmodule

// File: rtl/ddr_wr_deserializer.sv
module ddr_wr_deserializer #(
    parameter int BEAT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BEAT_W-1:0]   dq_in,
    input  logic                dqs_in,
    input  logic                wr_en,
    input  logic                wr_arm,
    output logic                word_evt,
    output logic [2*BEAT_W-1:0] wr_word,
    output logic                wr_valid
);

    logic [BEAT_W-1:0] lo_cap_q;
    logic [BEAT_W-1:0] hi_cap_q;
    logic              pair_tog_q;
    logic              seen_tog_q;

    // Strobe rising edge: first beat
    always_ff @(posedge dqs_in or negedge rst_n) begin
        if (!rst_n) lo_cap_q <= '0;
        else        lo_cap_q <= dq_in;
    end

    // Strobe falling edge: second beat, and mark a completed pair
    always_ff @(negedge dqs_in or negedge rst_n) begin
        if (!rst_n) begin
            hi_cap_q   <= '0;
            pair_tog_q <= 1'b0;
        end else begin
            hi_cap_q   <= dq_in;
            pair_tog_q <= ~pair_tog_q;
        end
    end

    assign word_evt = wr_en && (pair_tog_q != seen_tog_q);

    // Clock domain: accept a new pair once per clock while writing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_tog_q <= 1'b0;
            wr_word    <= '0;
            wr_valid   <= 1'b0;
        end else begin
            wr_valid <= 1'b0;
            if (wr_arm) begin
                seen_tog_q <= pair_tog_q;
            end else if (word_evt) begin
                seen_tog_q <= pair_tog_q;
                wr_word    <= {hi_cap_q, lo_cap_q};
                wr_valid   <= 1'b1;
            end
        end
    end

    // R6: a word is only ever presented right after a write cycle
    a_r6_valid_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(wr_en));

endmodule

// File: rtl/ddr_prefetch_serdes.sv
module ddr_prefetch_serdes
    import ddr_serdes_pkg::*;
#(
    parameter int BEAT_W    = 8,
    parameter int MAX_WORDS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_start,
    input  logic                wr_start,
    input  logic [1:0]          blen_sel,
    input  logic [2*BEAT_W-1:0] rd_word,
    output logic                rd_take,
    output logic [BEAT_W-1:0]   dq_out,
    output logic                dqs_out,
    output logic                pin_oe,
    input  logic [BEAT_W-1:0]   dq_in,
    input  logic                dqs_in,
    output logic [2*BEAT_W-1:0] wr_word,
    output logic                wr_valid
);

    burst_state_e state;
    logic         wr_en;
    logic         wr_arm;
    logic         word_evt;

    ddr_burst_ctrl #(.MAX_WORDS(MAX_WORDS)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_start (rd_start),
        .wr_start (wr_start),
        .blen_sel (blen_sel),
        .word_evt (word_evt),
        .state    (state),
        .rd_take  (rd_take),
        .wr_en    (wr_en),
        .wr_arm   (wr_arm)
    );

    ddr_rd_serializer #(.BEAT_W(BEAT_W)) ser_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_take (rd_take),
        .rd_word (rd_word),
        .dq_out  (dq_out),
        .dqs_out (dqs_out),
        .pin_oe  (pin_oe)
    );

    ddr_wr_deserializer #(.BEAT_W(BEAT_W)) des_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .dq_in    (dq_in),
        .dqs_in   (dqs_in),
        .wr_en    (wr_en),
        .wr_arm   (wr_arm),
        .word_evt (word_evt),
        .wr_word  (wr_word),
        .wr_valid (wr_valid)
    );

    // R7: pins are never driven while a write burst runs
    a_r7_no_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE) |-> !pin_oe);

    // R11: a simultaneous request pair in IDLE starts a read
    a_r11_read_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && rd_start && wr_start) |=> (state == ST_READ));

    // R5: with no word taken on the last edge, the strobe is quiet
    a_r5_quiet_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_take) |-> !pin_oe);

endmodule

// File: tb/ddr_prefetch_serdes_tb.sv
`timescale 1ns/1ps
module ddr_prefetch_serdes_tb_top;

    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_start = 1'b0;
    logic          wr_start = 1'b0;
    logic [1:0]    blen_sel = 2'd0;
    logic [15:0]   rd_word = '0;
    logic          rd_take;
    logic [BW-1:0] dq_out;
    logic          dqs_out;
    logic          pin_oe;
    logic [BW-1:0] dq_in = '0;
    logic          dqs_in = 1'b0;
    logic [15:0]   wr_word;
    logic          wr_valid;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    ddr_prefetch_serdes #(.BEAT_W(BW)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .wr_start(wr_start),
        .blen_sel(blen_sel), .rd_word(rd_word), .rd_take(rd_take),
        .dq_out(dq_out), .dqs_out(dqs_out), .pin_oe(pin_oe),
        .dq_in(dq_in), .dqs_in(dqs_in), .wr_word(wr_word), .wr_valid(wr_valid)
    );

    function automatic logic [15:0] pat(input int k);
        return {8'(k * 29 + 90), 8'(k * 13 + 33)};
    endfunction

    function automatic int words_of(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic strobe_pair(input logic [15:0] w);
        dq_in = w[7:0];
        #1 dqs_in = 1'b1;
        #1 dq_in = w[15:8];
        #1 dqs_in = 1'b0;
    endtask

    // Reset state (R1)
    task automatic t_reset();
        #3;
        chk("R1", "pin_oe in reset", 32'(pin_oe), 0);
        chk("R1", "dqs_out in reset", 32'(dqs_out), 0);
        chk("R1", "rd_take in reset", 32'(rd_take), 0);
        chk("R1", "wr_valid in reset", 32'(wr_valid), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R1", "pin_oe after reset", 32'(pin_oe), 0);
        chk("R1", "wr_valid after reset", 32'(wr_valid), 0);
    endtask

    // Read burst (R2 R3 R4 R5), optionally chained (R10), both starts (R11),
    // or poked with requests mid-burst (R9). Called at posedge+2.
    task automatic t_read(input logic [1:0] sel, input int base,
                          input bit chain, input bit both, input bit poke);
        int n = words_of(sel);
        int total = chain ? 2 * n : n;
        rd_start = 1'b1; wr_start = both; blen_sel = sel;
        @(posedge clk); #2;
        rd_start = 1'b0; wr_start = 1'b0;
        chk("R2", "rd_take first cycle", 32'(rd_take), 1);
        chk("R5", "pin_oe before first take", 32'(pin_oe), 0);
        for (int i = 0; i < total; i++) begin
            rd_word = pat(base + i);
            if (chain && i == n - 1) rd_start = 1'b1;
            if (poke && i == 0 && n > 1) begin rd_start = 1'b1; wr_start = 1'b1; end
            @(posedge clk); #2;
            rd_start = 1'b0; wr_start = 1'b0;
            chk("R3", "low half in high phase", 32'(dq_out), 32'(pat(base + i) & 16'h00FF));
            chk("R4", "strobe high phase", 32'(dqs_out), 1);
            chk("R4", "pin_oe during beat", 32'(pin_oe), 1);
            chk(chain ? "R10" : (poke ? "R9" : "R2"), "rd_take window",
                32'(rd_take), (i < total - 1) ? 1 : 0);
            @(negedge clk); #2;
            chk("R3", "high half in low phase", 32'(dq_out), 32'(pat(base + i) >> 8));
            chk("R4", "strobe low phase", 32'(dqs_out), 0);
        end
        @(posedge clk); #2;
        chk("R5", "pin_oe after burst", 32'(pin_oe), 0);
        chk("R5", "dqs_out after burst", 32'(dqs_out), 0);
        @(negedge clk); #2;
        chk("R5", "dqs_out low phase idle", 32'(dqs_out), 0);
        if (both || poke) begin
            chk(both ? "R11" : "R9", "no write word after", 32'(wr_valid), 0);
            chk(both ? "R11" : "R9", "rd_take idle after", 32'(rd_take), 0);
        end
        @(posedge clk); #2;
    endtask

    // Write burst (R6 R7), with optional read request poked in (R9).
    task automatic t_write(input logic [1:0] sel, input int base, input bit poke);
        int n = words_of(sel);
        wr_start = 1'b1; blen_sel = sel;
        @(posedge clk); #2;
        wr_start = 1'b0;
        for (int j = 0; j < n; j++) begin
            if (poke && j == 0) rd_start = 1'b1;
            strobe_pair(pat(base + j));
            chk("R7", "pin_oe low in write", 32'(pin_oe), 0);
            @(posedge clk); #2;
            rd_start = 1'b0;
            chk("R6", "wr_valid pulse", 32'(wr_valid), 1);
            chk("R6", "wr_word value", 32'(wr_word), 32'(pat(base + j)));
            if (poke) chk("R9", "no read during write", 32'(rd_take), 0);
        end
        strobe_pair(16'hDEAD);
        @(posedge clk); #2;
        chk("R7", "no word past burst", 32'(wr_valid), 0);
        chk("R7", "pin_oe idle after write", 32'(pin_oe), 0);
        @(posedge clk); #2;
        chk("R7", "still no word", 32'(wr_valid), 0);
    endtask

    // Stray strobe pulses in IDLE (R8)
    task automatic t_stray();
        for (int k = 0; k < 3; k++) begin
            strobe_pair(16'hBEEF + 16'(k));
            @(posedge clk); #2;
            chk("R8", "stray strobe ignored", 32'(wr_valid), 0);
        end
    endtask

    initial begin
        t_reset();
        t_read(2'd0, 0, 1'b0, 1'b0, 1'b0);
        t_read(2'd1, 10, 1'b0, 1'b0, 1'b0);
        t_read(2'd2, 20, 1'b0, 1'b0, 1'b0);
        t_read(2'd3, 30, 1'b0, 1'b0, 1'b0);
        t_read(2'd1, 40, 1'b1, 1'b0, 1'b0);
        t_read(2'd0, 50, 1'b1, 1'b0, 1'b0);
        t_read(2'd2, 60, 1'b0, 1'b1, 1'b0);
        t_read(2'd2, 70, 1'b0, 1'b0, 1'b1);
        t_write(2'd0, 80, 1'b0);
        t_write(2'd2, 90, 1'b0);
        t_stray();
        t_write(2'd1, 100, 1'b0);
        t_stray();
        t_write(2'd2, 110, 1'b1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule